// File: doc/BRIEF.md
# Configuration Packet Broadcast Fan-Out

This block takes 32-bit writes from a host bus and assembles them into 128-bit configuration packets. It then hands each finished packet to every connected downstream frame controller at the same moment. There are two 4 KiB write windows, selected by `reqWin`. In the command window (`reqWin` = 0), the write that completes a packet also picks the 6-bit target register code from its address. In the frame-data window (`reqWin` = 1), every packet is tagged with one fixed frame-data code, set by the parameter `FRAME_DATA_CODE` (default 4).

Bits [3:2] of each write address select one of four word slots. Each window has its own set of four slots. Writing slot 3 completes a packet. The packet takes the slot-3 value together with whatever the other three slots of that window last held. At completion, the block latches a copy of `portEnable`. It then raises a per-port valid for each enabled port, and each such valid stays up until its port's ready is seen. While any port has not yet taken the packet, the host interface stalls (`reqReady` low). Reads, and writes that are not word aligned, are refused: a read returns zero data, and either kind raises a one-cycle error pulse.

Top module: `cfg_bcast_fanout`

## Requirements
- R1: After reset, `reqReady` is 1, `pktValid` and `reqErr` are 0, and all eight slot words of both windows are zero.
- R2: A write is accepted on a rising edge where `reqValid` and `reqReady` are both 1. An aligned write stores `reqWdata` in slot `reqAddr[3:2]` of window `reqWin`. A write to slot 3 completes a packet on that edge, and from the next cycle `pktData[32*i+31:32*i]` holds slot i of that window.
- R3: A packet completed in the command window carries `pktRegCode` equal to `reqAddr[9:4]` of the completing write.
- R4: A packet completed in the frame-data window carries `pktRegCode` equal to `FRAME_DATA_CODE`, whatever the address.
- R5: In the cycle after completion, `pktValid` equals the value `portEnable` had on the completing edge. Ports that were not enabled never see valid for that packet.
- R6: Once a bit of `pktValid` is set, it stays set until an edge on which the same bit of `portReady` is 1. It is clear from the following cycle.
- R7: `reqReady` is 0 while any bit of `pktValid` is set. Requests offered during that time are neither stored nor refused; they wait.
- R8: An accepted read changes no state. `rdData` is zero, and `reqErr` is 1 for exactly the cycle after the read.
- R9: An accepted write with `reqAddr[1:0]` nonzero stores nothing and completes no packet, and `reqErr` is 1 for the cycle after it.
- R10: Writes to one window never alter the slot words of the other window.
- R11: Slots 0 to 2 keep their last written value across packets. A packet completed by a lone slot-3 write reuses them.
- R12: A packet completed while `portEnable` is all zero is dropped: `pktValid` stays 0 and `reqReady` stays 1.
- R13: While any port still has the packet pending, `pktData` and `pktRegCode` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWin | input | 1 | 0 = command window, 1 = frame-data window |
| reqAddr | input | ADDR_W | Byte offset inside the 4 KiB window |
| reqWdata | input | WORD_W | Write data |
| reqReady | output | 1 | Request accepted on this edge when high |
| rdData | output | WORD_W | Read data, always zero |
| reqErr | output | 1 | One-cycle pulse after a refused access |
| portEnable | input | NUM_PORTS | Ports wired to a controller |
| portReady | input | NUM_PORTS | Per-port packet acceptance |
| pktValid | output | NUM_PORTS | Per-port packet offer |
| pktRegCode | output | CODE_W | Target register code of the packet |
| pktData | output | 4*WORD_W | Packet payload, slot 0 in the low word |

## Verification
Several properties are checked on every cycle by assertions. These cover the launch mask matching the sampled enables, each valid holding until its own ready, the payload and code staying frozen while delivery is pending, and the rules that a refused access stores nothing and that no write is stored while delivery is busy. Other behaviour only shows up across a scenario, so the bench has to exercise it. That includes which words end up in a packet after interleaved traffic to both windows, reuse of stale slots, independence of the two windows, a reset that wipes a half-built packet, and a packet dropped when no port is enabled. The bench's behavioural model follows each of these over time.

// File: rtl/cfg_bcast_pkg.sv
package cfg_bcast_pkg;
  localparam int CODE_W = 6;
  localparam int SLOT_W = 2;

  typedef struct packed {
    logic              wrEn;
    logic              win;
    logic [SLOT_W-1:0] slot;
    logic              launch;
    logic [CODE_W-1:0] regCode;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfg_bcast_ctrl.sv
module cfg_bcast_ctrl
  import cfg_bcast_pkg::*;
#(
  parameter int NUM_PORTS       = 15,
  parameter int ADDR_W          = 12,
  parameter int FRAME_DATA_CODE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqWin,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_PORTS-1:0] portEnable,
  input  logic [NUM_PORTS-1:0] portReady,
  output ctrlStrobe_t          strb,
  output logic [NUM_PORTS-1:0] pktValid,
  output logic                 reqReady,
  output logic                 reqErr
);
  localparam int CODE_LSB = 4;
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  logic [NUM_PORTS-1:0] pendQ;
  logic                 errQ;
  logic                 accept;
  logic                 aligned;
  logic                 goodWr;
  logic                 unusedAddrHi;

  assign unusedAddrHi = ^reqAddr[ADDR_W-1:CODE_MSB+1];

  assign reqReady = ~|pendQ;
  assign accept   = reqValid & reqReady;
  assign aligned  = (reqAddr[1:0] == 2'b00);
  assign goodWr   = accept & reqWrite & aligned;

  always_comb begin
    strb.wrEn    = goodWr;
    strb.win     = reqWin;
    strb.slot    = reqAddr[3:2];
    strb.launch  = goodWr && (reqAddr[3:2] == LAST_SLOT);
    strb.regCode = reqWin ? CODE_W'(FRAME_DATA_CODE) : reqAddr[CODE_MSB:CODE_LSB];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (strb.launch) pendQ <= portEnable;
      else             pendQ <= pendQ & ~portReady;
      errQ <= accept & ~(reqWrite & aligned);
    end
  end

  assign pktValid = pendQ;
  assign reqErr   = errQ;

  // R5: the launched valid mask is the enables sampled at completion
  a_r5_launch_mask: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> (pktValid == $past(portEnable)));

  // R6: a pending port keeps valid until it shows ready
  a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    (|(pktValid & ~portReady)) |=>
      ((pktValid & $past(pktValid & ~portReady)) == $past(pktValid & ~portReady)));

  // R7: nothing is stored while delivery is outstanding
  a_r7_no_store_busy: assert property (@(posedge clk) disable iff (!rstN)
    (|pktValid) |-> !strb.wrEn);

  // R9: a misaligned write stores nothing and is flagged next cycle
  a_r9_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && (reqAddr[1:0] != 2'b00)) |->
      (!strb.wrEn ##1 reqErr));
endmodule

// File: rtl/cfg_bcast_dpath.sv
module cfg_bcast_dpath
  import cfg_bcast_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [WORD_W-1:0]   reqWdata,
  output logic [CODE_W-1:0]   pktRegCode,
  output logic [4*WORD_W-1:0] pktData
);
  localparam int NUM_WIN   = 2;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  logic [WORD_W-1:0] bufQ [NUM_WIN][NUM_SLOTS];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN)
          bufQ[w][s] <= '0;
        else if (strb.wrEn && (strb.win == 1'(w)) && (strb.slot == SLOT_W'(s)))
          bufQ[w][s] <= reqWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktData    <= '0;
      pktRegCode <= '0;
    end else if (strb.launch) begin
      pktData    <= {reqWdata, bufQ[strb.win][2], bufQ[strb.win][1], bufQ[strb.win][0]};
      pktRegCode <= strb.regCode;
    end
  end

  // R2: the completing word lands in the top word of the packet
  a_r2_slot3_word: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> (pktData[4*WORD_W-1:3*WORD_W] == $past(reqWdata)));
endmodule

// File: rtl/cfg_bcast_fanout.sv
module cfg_bcast_fanout
  import cfg_bcast_pkg::*;
#(
  parameter int NUM_PORTS       = 15,
  parameter int WORD_W          = 32,
  parameter int ADDR_W          = 12,
  parameter int FRAME_DATA_CODE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqWin,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [WORD_W-1:0]    reqWdata,
  output logic                 reqReady,
  output logic [WORD_W-1:0]    rdData,
  output logic                 reqErr,
  input  logic [NUM_PORTS-1:0] portEnable,
  input  logic [NUM_PORTS-1:0] portReady,
  output logic [NUM_PORTS-1:0] pktValid,
  output logic [CODE_W-1:0]    pktRegCode,
  output logic [4*WORD_W-1:0]  pktData
);
  ctrlStrobe_t strb;

  cfg_bcast_ctrl #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .FRAME_DATA_CODE(FRAME_DATA_CODE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWin(reqWin), .reqAddr(reqAddr), .portEnable(portEnable),
    .portReady(portReady), .strb(strb), .pktValid(pktValid),
    .reqReady(reqReady), .reqErr(reqErr)
  );

  cfg_bcast_dpath #(.WORD_W(WORD_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWdata(reqWdata),
    .pktRegCode(pktRegCode), .pktData(pktData)
  );

  assign rdData = '0;

  // R13: payload and code are frozen while any port is still pending
  a_r13_payload_stable: assert property (@(posedge clk) disable iff (!rstN)
    (|(pktValid & ~portReady)) |=> ($stable(pktData) && $stable(pktRegCode)));

  // R8: an accepted read raises the error pulse and launches nothing
  a_r8_read_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> (reqErr && (pktValid == '0)));
endmodule

// File: tb/cfg_bcast_fanout_tb_top.sv
module cfg_bcast_fanout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 15;
  localparam int FDC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWin = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, reqErr;
  logic [31:0] rdData;
  logic [NP-1:0] portEnable = '0, portReady = '0, pktValid;
  logic [5:0] pktRegCode;
  logic [127:0] pktData;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] mBuf [2][4];
  logic [NP-1:0] mPend;
  logic [127:0] mData;
  logic [5:0] mCode;
  logic mErr;

  cfg_bcast_fanout #(.NUM_PORTS(NP), .FRAME_DATA_CODE(FDC)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWin(reqWin), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rdData(rdData), .reqErr(reqErr),
    .portEnable(portEnable), .portReady(portReady), .pktValid(pktValid),
    .pktRegCode(pktRegCode), .pktData(pktData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < 2; w++) for (int s = 0; s < 4; s++) mBuf[w][s] = '0;
      mPend = '0; mData = '0; mCode = '0; mErr = 0;
    end else begin
      logic acc;
      logic [NP-1:0] nxt;
      acc = reqValid && (mPend == '0);
      nxt = mPend & ~portReady;
      mErr = 0;
      if (acc) begin
        if (!reqWrite || reqAddr[1:0] != 0) mErr = 1;
        else begin
          mBuf[reqWin][reqAddr[3:2]] = reqWdata;
          if (reqAddr[3:2] == 3) begin
            mData = {mBuf[reqWin][3], mBuf[reqWin][2], mBuf[reqWin][1], mBuf[reqWin][0]};
            mCode = reqWin ? 6'(FDC) : reqAddr[9:4];
            nxt = portEnable;
          end
        end
      end
      mPend = nxt;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R5/R6 pktValid", 128'(pktValid), 128'(mPend));
      chk("R7 reqReady", 128'(reqReady), 128'(mPend == '0));
      chk("R8/R9 reqErr", 128'(reqErr), 128'(mErr));
      chk("R8 rdData", 128'(rdData), 128'(0));
      if (mPend != '0) begin
        chk("R2/R11/R13 pktData", pktData, mData);
        chk("R3/R4 pktRegCode", 128'(pktRegCode), 128'(mCode));
      end
    end
  end

  task automatic access(input logic wr, input logic win, input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqWin = win; reqAddr = addr; reqWdata = data;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic packet(input logic win, input logic [11:0] base, input logic [31:0] seed);
    for (int s = 0; s < 4; s++) access(1, win, base | 12'(s*4), seed + 32'(s));
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reqReady", 128'(reqReady), 128'(1));
    chk("R1 pktValid", 128'(pktValid), 128'(0));
    chk("R1 reqErr", 128'(reqErr), 128'(0));

    // R2 R3: command window, all ports ready
    portEnable = '1; portReady = '1;
    packet(0, 12'h150, 32'hA000_0000);
    chk("R3 code from addr[9:4]", 128'(pktRegCode), 128'(6'h15));
    chk("R2 word order", pktData, {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000});
    @(negedge clk);
    chk("R6 cleared after ready", 128'(pktValid), 128'(0));

    // R4 R5 R6 R7 R13: data window, two enabled ports, slow accept, stalled write
    portEnable = 15'h0005; portReady = '0;
    packet(1, 12'h3F0, 32'hB000_0000);
    chk("R4 frame data code", 128'(pktRegCode), 128'(FDC));
    chk("R5 only enabled ports", 128'(pktValid), 128'(15'h0005));
    fork
      access(1, 0, 12'h000, 32'hC0C0_0000);
      begin
        repeat (3) @(negedge clk);
        chk("R7 stalled", 128'(reqReady), 128'(0));
        portReady = 15'h0001;
        @(negedge clk);
        chk("R6 port0 done port2 held", 128'(pktValid), 128'(15'h0004));
        portReady = 15'h0004;
      end
    join
    portReady = '1;
    repeat (2) @(negedge clk);

    // R11: lone slot-3 write reuses command-window slots (slot0 now C0C00000)
    portEnable = 15'h7FFF;
    access(1, 0, 12'h3FC, 32'hD000_0003);
    chk("R11 stale slots reused", pktData, {32'hD000_0003, 32'hA000_0002, 32'hA000_0001, 32'hC0C0_0000});
    chk("R3 code 3F", 128'(pktRegCode), 128'(6'h3F));

    // R10: data-window writes do not disturb the command window
    access(1, 1, 12'h000, 32'hE000_0000);
    access(1, 1, 12'h004, 32'hE000_0001);
    access(1, 0, 12'h00C, 32'hF000_0003);
    chk("R10 windows separate", pktData, {32'hF000_0003, 32'hA000_0002, 32'hA000_0001, 32'hC0C0_0000});

    // R8 read, R9 misaligned write
    access(0, 0, 12'h00C, 32'h0);
    chk("R8 read error", 128'(reqErr), 128'(1));
    access(1, 1, 12'h00E, 32'h1234_5678);
    chk("R9 misaligned error", 128'(reqErr), 128'(1));
    chk("R9 no launch", 128'(pktValid), 128'(0));

    // R12: no enabled port
    portEnable = '0;
    access(1, 1, 12'h00C, 32'h5555_0003);
    chk("R12 dropped valid", 128'(pktValid), 128'(0));
    chk("R12 ready kept", 128'(reqReady), 128'(1));

    // R1: reset wipes a partial packet
    portEnable = '1;
    access(1, 0, 12'h000, 32'h7777_7777);
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk); rstN = 1;
    access(1, 0, 12'h00C, 32'h9999_0003);
    chk("R1 buffers cleared", pktData, {32'h9999_0003, 96'h0});

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule